// File: doc/BRIEF.md
# Multiplexed Transmit Line Scanner

This block is the transmit side of a serial multiplexer with several output lines. All of them share one transmit data register and one ready flag. Software enables lines individually. While master scanning is switched on, a scanner visits the lines one per clock cycle. It parks on the first enabled line that has no character in progress. It then raises the ready flag and reports that line number in the control/status register. A write to the transmit data register hands the character to the parked line, drops the flag and moves the scanner on to the following line in round-robin order.

Each line's shift-out is modelled as a busy timer of fixed length. Baud generation and framing are not part of the block. An interrupt output follows the ready flag when interrupts are enabled. A self-timed clear operation returns every register to its reset state. The line-enable register also holds an active-low data-terminal-ready control bit for the modem line.

Top module: `mux_tx_scanner`

## Requirements
- R1: The ready flag is raised only for a line whose enable bit (bit n of the line-enable register at address 1 controls line n) is set. Clearing the parked line's enable bit withdraws the offer, and scanning continues with the next enabled line.
- R2: The control/status register at address 0 shows the ready flag in bit 15 and the parked line number in the field that starts at bit 8. Bit 1 is the master scan enable and bit 2 is the transmit interrupt enable.
- R3: A write to address 2 while ready is high accepts exactly one character (bits 7:0). That character goes to the reported line, which goes busy on `ln_busy_o`, and the ready flag drops in the following cycle.
- R4: A write to address 2 while ready is low has no effect. No line goes busy and `ln_char_o` keeps its value.
- R5: While the master scan enable is 0, the ready flag stays low.
- R6: `tx_irq_o` is high exactly when both the ready flag and the interrupt enable are set.
- R7: Writing 1 to bit 0 of address 0 clears all registers and line timers. Bit 0 reads 1 for 8 cycles and then self-clears. Register writes during this time are ignored.
- R8: Address 3 reads a per-line empty flag in bit n. A line is empty only when its enable bit is clear and it has no character in progress.
- R9: Bit 12 of address 1 is an active-low DTR control for the modem line. It resets to 1, and writing 0 asserts `modem_dtr_o`.
- R10: After a character is accepted, the next line offered is the first enabled idle line after the serviced one, in ascending cyclic order.
- R11: A line stays busy for 16 cycles after it accepts a character, and it is not offered again during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address for reads and writes |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register |
| tx_irq_o | output | 1 | Transmit interrupt |
| ln_busy_o | output | 4 | Per-line character-in-progress flag |
| ln_char_o | output | 8 | Last accepted character |
| modem_dtr_o | output | 1 | Modem line DTR, active high at the pin |

## Verification
Random non-empty enable masks are applied while the scanner is parked on a line. Each mask checks that the offered line is the first enabled one at or after the parked position. The character that follows checks that the next offer skips to the first enabled line after the serviced one. A single-line mask separates round-robin advance from busy blocking, because that line is offered again only after its timer runs out. Directed cases cover writes while ready is low, scanning switched off, enable removal during a busy period, and the clear sequence with a write landing inside it.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int CHAR_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 2'd0,
    RA_LINE_EN = 2'd1,
    RA_TXDATA  = 2'd2,
    RA_EMPTY   = 2'd3
  } reg_addr_e;

  // control/status bit positions
  localparam int CTRL_CLR      = 0;
  localparam int CTRL_SCAN     = 1;
  localparam int CTRL_TXIE     = 2;
  localparam int CTRL_LINE_LSB = 8;
  localparam int CTRL_RDY      = 15;

  // line-enable register: modem DTR control (active low)
  localparam int LEN_DTRN = 12;
endpackage

// File: rtl/txs_regs.sv
module txs_regs
  import txs_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int CLR_CYCLES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic                 scan_en_o,
  output logic                 tx_ie_o,
  output logic [NUM_LINES-1:0] line_en_o,
  output logic                 dtr_n_o,
  output logic                 clr_busy_o,
  output logic                 tdr_wr_o
);
  localparam int CLR_W = $clog2(CLR_CYCLES + 1);

  logic                 scan_q, scan_d;
  logic                 ie_q, ie_d;
  logic                 dtrn_q, dtrn_d;
  logic [NUM_LINES-1:0] en_q, en_d;
  logic [CLR_W-1:0]     clr_q, clr_d;
  logic                 clr_busy;
  logic                 wr_ok;

  assign clr_busy = (clr_q != '0);
  assign wr_ok    = wr_i && !clr_busy;

  always_comb begin
    scan_d = scan_q;
    ie_d   = ie_q;
    dtrn_d = dtrn_q;
    en_d   = en_q;
    clr_d  = clr_q;
    if (clr_busy) begin
      clr_d = clr_q - 1'b1;
    end
    if (wr_ok) begin
      unique case (addr_i)
        RA_CTRL: begin
          if (wdata_i[CTRL_CLR]) begin
            clr_d  = CLR_W'(CLR_CYCLES);
            scan_d = 1'b0;
            ie_d   = 1'b0;
            en_d   = '0;
            dtrn_d = 1'b1;
          end else begin
            scan_d = wdata_i[CTRL_SCAN];
            ie_d   = wdata_i[CTRL_TXIE];
          end
        end
        RA_LINE_EN: begin
          en_d   = wdata_i[NUM_LINES-1:0];
          dtrn_d = wdata_i[LEN_DTRN];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= 1'b0;
      ie_q   <= 1'b0;
      dtrn_q <= 1'b1;
      en_q   <= '0;
      clr_q  <= '0;
    end else begin
      scan_q <= scan_d;
      ie_q   <= ie_d;
      dtrn_q <= dtrn_d;
      en_q   <= en_d;
      clr_q  <= clr_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign scan_en_o  = scan_q;
  assign tx_ie_o    = ie_q;
  assign line_en_o  = en_q;
  assign dtr_n_o    = dtrn_q;
  assign clr_busy_o = clr_busy;
  assign tdr_wr_o   = wr_ok && (addr_i == RA_TXDATA);
endmodule

// File: rtl/txs_scan.sv
module txs_scan #(
  parameter int NUM_LINES = 4,
  parameter int LINE_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 scan_en_i,
  input  logic [NUM_LINES-1:0] line_en_i,
  input  logic [NUM_LINES-1:0] line_busy_i,
  input  logic                 tdr_wr_i,
  output logic                 rdy_o,
  output logic [LINE_W-1:0]    line_o,
  output logic                 accept_o,
  output logic [NUM_LINES-1:0] load_o
);
  logic              rdy_q, rdy_d;
  logic [LINE_W-1:0] ptr_q, ptr_d, ptr_nxt;
  logic              accept;

  assign accept  = tdr_wr_i && rdy_q;
  assign ptr_nxt = (ptr_q == LINE_W'(NUM_LINES - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    rdy_d = rdy_q;
    ptr_d = ptr_q;
    if (flush_i) begin
      rdy_d = 1'b0;
      ptr_d = '0;
    end else if (accept) begin
      rdy_d = 1'b0;
      ptr_d = ptr_nxt;
    end else if (!scan_en_i) begin
      rdy_d = 1'b0;
    end else if (rdy_q) begin
      if (!line_en_i[ptr_q]) begin
        rdy_d = 1'b0;
        ptr_d = ptr_nxt;
      end
    end else if (line_en_i[ptr_q] && !line_busy_i[ptr_q]) begin
      rdy_d = 1'b1;
    end else begin
      ptr_d = ptr_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      ptr_q <= ptr_d;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_load
    assign load_o[g] = accept && (ptr_q == LINE_W'(g));
  end

  assign rdy_o    = rdy_q;
  assign line_o   = ptr_q;
  assign accept_o = accept;
endmodule

// File: rtl/txs_line_timer.sv
module txs_line_timer #(
  parameter int CHAR_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CHAR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (flush_i) begin
      cnt_d = '0;
    end else if (load_i) begin
      cnt_d = CNT_W'(CHAR_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mux_tx_scanner.sv
module mux_tx_scanner
  import txs_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int CHAR_CYCLES = 16,
  parameter int CLR_CYCLES  = 8,
  parameter int MODEM_LINE  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     bus_rdata_o,
  output logic                 tx_irq_o,
  output logic [NUM_LINES-1:0] ln_busy_o,
  output logic [CHAR_W-1:0]    ln_char_o,
  output logic                 modem_dtr_o
);
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int MODEM_IDX = MODEM_LINE;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                 scan_en, tx_ie, dtr_n, clr_busy, tdr_wr;
  logic [NUM_LINES-1:0] line_en, line_busy, load;
  logic                 rdy, accept;
  logic [LINE_W-1:0]    line;

  txs_regs #(
    .NUM_LINES (NUM_LINES),
    .CLR_CYCLES(CLR_CYCLES)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .scan_en_o (scan_en),
    .tx_ie_o   (tx_ie),
    .line_en_o (line_en),
    .dtr_n_o   (dtr_n),
    .clr_busy_o(clr_busy),
    .tdr_wr_o  (tdr_wr)
  );

  txs_scan #(
    .NUM_LINES(NUM_LINES),
    .LINE_W   (LINE_W)
  ) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .flush_i    (clr_busy),
    .scan_en_i  (scan_en),
    .line_en_i  (line_en),
    .line_busy_i(line_busy),
    .tdr_wr_i   (tdr_wr),
    .rdy_o      (rdy),
    .line_o     (line),
    .accept_o   (accept),
    .load_o     (load)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    txs_line_timer #(
      .CHAR_CYCLES(CHAR_CYCLES)
    ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .flush_i(clr_busy),
      .load_i (load[g]),
      .busy_o (line_busy[g])
    );
  end

  // character presented to the line being shifted
  logic [CHAR_W-1:0] char_q, char_d;
  always_comb begin
    char_d = char_q;
    if (accept) char_d = bus_wdata_i[CHAR_W-1:0];
  end
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) char_q <= '0;
    else             char_q <= char_d;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      RA_CTRL: begin
        bus_rdata_o[CTRL_CLR]                  = clr_busy;
        bus_rdata_o[CTRL_SCAN]                 = scan_en;
        bus_rdata_o[CTRL_TXIE]                 = tx_ie;
        bus_rdata_o[CTRL_LINE_LSB +: LINE_W]   = line;
        bus_rdata_o[CTRL_RDY]                  = rdy;
      end
      RA_LINE_EN: begin
        bus_rdata_o[NUM_LINES-1:0] = line_en;
        bus_rdata_o[LEN_DTRN]      = dtr_n;
      end
      RA_EMPTY: bus_rdata_o[NUM_LINES-1:0] = ~line_en & ~line_busy;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign tx_irq_o    = rdy && tx_ie;
  assign ln_busy_o   = line_busy;
  assign ln_char_o   = char_q;
  assign modem_dtr_o = (MODEM_IDX < NUM_LINES) ? !dtr_n : 1'b0;
endmodule

// File: rtl/mux_tx_scanner_chk.sv
module mux_tx_scanner_chk #(
  parameter int NUM_LINES = 4,
  parameter int LINE_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rdy,
  input logic [LINE_W-1:0]    line,
  input logic                 scan_en,
  input logic                 tx_ie,
  input logic                 tx_irq,
  input logic                 tdr_wr,
  input logic                 clr_busy,
  input logic [NUM_LINES-1:0] line_en,
  input logic [NUM_LINES-1:0] line_busy
);
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (rdy && tx_ie)); // R6

  AST_PARKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !tdr_wr && scan_en && line_en[line] && !clr_busy) |=> (rdy && $stable(line))); // R1

  AST_OFFER_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> !line_busy[line]); // R11

  AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_wr && rdy) |=> !rdy); // R3

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(line_busy & ~$past(line_busy)) <= 1); // R3

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_wr && !rdy) |=> ((line_busy & ~$past(line_busy)) == '0)); // R4

  AST_SCAN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !rdy); // R5

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> !rdy); // R7
endmodule

bind mux_tx_scanner mux_tx_scanner_chk #(
  .NUM_LINES(NUM_LINES),
  .LINE_W   (LINE_W)
) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_sync_n),
  .rdy      (rdy),
  .line     (line),
  .scan_en  (scan_en),
  .tx_ie    (tx_ie),
  .tx_irq   (tx_irq_o),
  .tdr_wr   (tdr_wr),
  .clr_busy (clr_busy),
  .line_en  (line_en),
  .line_busy(line_busy)
);

// File: tb/test_mux_tx_scanner.sv
module test_mux_tx_scanner;
  localparam int NL    = 4;
  localparam int CHARC = 16;
  localparam int CLRC  = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LEN  = 2'd1;
  localparam logic [1:0] A_TX   = 2'd2;
  localparam logic [1:0] A_EMP  = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tx_irq;
  logic [NL-1:0] ln_busy;
  logic [7:0]  ln_char;
  logic        modem_dtr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mux_tx_scanner #(
    .NUM_LINES(NL), .CHAR_CYCLES(CHARC), .CLR_CYCLES(CLRC), .MODEM_LINE(3)
  ) i_mux_tx_scanner (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tx_irq_o(tx_irq),
    .ln_busy_o(ln_busy), .ln_char_o(ln_char), .modem_dtr_o(modem_dtr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int first_from(input int start, input logic [NL-1:0] m);
    for (int k = 0; k < NL; k++)
      if (m[(start + k) % NL]) return (start + k) % NL;
    return -1;
  endfunction

  function automatic logic [NL-1:0] onehot(input int i);
    return NL'(1) << i;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [NL-1:0] mask;
    logic [7:0] ch;
    int cur, nxt, exp;
    int unsigned sd;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    sd = $urandom(32'd2024);
    idle(4); rst_n = 1'b1; idle(4);

    rd(A_CTRL, v); check("R7 reset control", v, 16'h0000);
    rd(A_LEN, v);  check("R9 reset line-enable", v, 16'h1000);
    rd(A_EMP, v);  check("R8 reset empty", v, 16'h000F);
    check("R9 dtr idle", modem_dtr, 0);
    check("R6 irq idle", tx_irq, 0);

    wr(A_LEN, 16'h100F); idle(10);
    rd(A_CTRL, v); check("R5 no ready without scan", v[15], 0);

    wr(A_CTRL, 16'h0006); idle(8);
    rd(A_CTRL, v);
    check("R2 ready bit", v[15], 1);
    check("R2 line field", v[9:8], 0);
    check("R6 irq with ready and enable", tx_irq, 1);
    wr(A_CTRL, 16'h0002);
    rd(A_CTRL, v);
    check("R6 irq masked", tx_irq, 0);
    check("R2 ready kept", v[15], 1);

    cur = 0;
    for (int it = 0; it < 40; it++) begin
      mask = NL'(($urandom % 15) + 1);
      wr(A_LEN, 16'h1000 | 16'(mask)); idle(8);
      exp = first_from(cur, mask);
      rd(A_CTRL, v);
      check("R1 ready on enabled line", v[15], 1);
      check("R1 offered line", 32'(v[9:8]), exp);
      ch = 8'($urandom);
      wr(A_TX, {8'h00, ch});
      rd(A_CTRL, v);
      check("R3 ready drops", v[15], 0);
      check("R3 only target busy", ln_busy, onehot(exp));
      check("R3 char delivered", ln_char, ch);
      idle(CHARC + 8);
      nxt = first_from((exp + 1) % NL, mask);
      rd(A_CTRL, v);
      check("R10 ready again", v[15], 1);
      check("R10 round robin line", 32'(v[9:8]), nxt);
      cur = nxt;
    end

    wr(A_LEN, 16'h1004); idle(8);
    rd(A_CTRL, v);
    check("R1 single line offered", 32'(v[9:8]), 2);
    wr(A_TX, 16'h003C);
    idle(CHARC - 1);
    rd(A_CTRL, v);
    check("R11 busy near end", ln_busy[2], 1);
    check("R11 not offered while busy", v[15], 0);
    idle(1);
    check("R11 busy ends", ln_busy[2], 0);
    idle(8);
    rd(A_CTRL, v);
    check("R11 offered after busy", v[15], 1);
    check("R11 same line", 32'(v[9:8]), 2);

    wr(A_CTRL, 16'h0000); idle(3);
    rd(A_CTRL, v);
    check("R5 ready drops with scan off", v[15], 0);
    wr(A_TX, 16'h00A5);
    check("R4 no line busy", ln_busy, 0);
    check("R4 char unchanged", ln_char, 8'h3C);
    wr(A_CTRL, 16'h0002); idle(8);
    rd(A_CTRL, v);
    check("R4 offer still pending", v[15], 1);

    wr(A_LEN, 16'h100F); idle(4);
    rd(A_EMP, v); check("R8 enabled idle not empty", v, 16'h0000);
    wr(A_TX, 16'h0011);
    wr(A_LEN, 16'h1000);
    rd(A_EMP, v); check("R8 busy line not empty", v, 16'h000B);
    idle(CHARC + 2);
    rd(A_EMP, v); check("R8 all empty", v, 16'h000F);

    wr(A_LEN, 16'h0000);
    check("R9 dtr asserted", modem_dtr, 1);
    wr(A_LEN, 16'h1000);
    check("R9 dtr released", modem_dtr, 0);

    wr(A_CTRL, 16'h0006); wr(A_LEN, 16'h100F); idle(8);
    check("R6 irq before clear", tx_irq, 1);
    wr(A_CTRL, 16'h0001);
    rd(A_CTRL, v);
    check("R7 clear bit reads one", v[0], 1);
    check("R7 irq off during clear", tx_irq, 0);
    wr(A_LEN, 16'h000F);
    rd(A_LEN, v); check("R7 write ignored during clear", v, 16'h1000);
    idle(CLRC + 2);
    rd(A_CTRL, v); check("R7 clear self-clears", v, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule